// File: doc/BRIEF.md
# Programmable Bit-Pattern Condition Evaluator

This block tests two operand words against one of several conditions that are fixed when the design is elaborated. Each condition is a sum of products. A product row places a requirement on every bit position. The first operand bit can be forced to 0, forced to 1 or ignored. The second operand bit can be tested in the same way, independently. As a further option, the two bits at a position can be required to be equal. A row is true only when every one of its bit tests passes. A condition is true when any of its enabled rows is true. A binary select input picks which condition drives the single result bit.

Each row is described by five parameter masks and one enable bit: a care mask and a value mask for each operand, and a mask that marks which positions must be equal. With these, one unit can answer questions such as "is the first word zero", "are both words identical" or "does the tag field of the second word hold the integer code". The evaluation is purely combinational. A datapath places it directly beside the buses and uses its output as a branch or trap condition in the same cycle. The built-in table holds five conditions of two rows each, numbered 0 to 4. Users may also supply their own flat mask vectors instead.

Top module: `bitpat_cond_eval`

## Requirements
- R1: For a row with a first-operand care bit set, the row passes at that position only when the `d1` bit equals the row's value bit. Built-in condition 0 exercises this on all bits.
- R2: For a row with a second-operand care bit set, the row passes at that position only when the `d2` bit equals the row's value bit. Built-in condition 2 exercises this on the tag bits.
- R3: For a row with an equality care bit set, the row passes at that position only when the `d1` and `d2` bits are equal. Built-in condition 1 exercises this on all bits.
- R4: A row is true only when every bit test in it passes. A single mismatching bit among the six tag bits makes built-in condition 2 false.
- R5: A condition is the OR of its enabled rows. Built-in condition 3 has one row testing `d1[0]==1` and one row testing `d2[0]==1`. It is true when either of them holds.
- R6: A disabled row contributes nothing, even when its masks would match. A condition with no enabled rows is 0. Built-in condition 4 has one disabled all-zero test on `d1` and is always 0.
- R7: A `sel` value equal to or above the number of conditions gives `result` = 0. With the built-in table this applies to `sel` values 5, 6 and 7.
- R8: With `sel` = 0, `result` is 1 exactly when `d1` is all zeros.
- R9: With `sel` = 1, `result` is 1 exactly when `d1` equals `d2` in every bit.
- R10: With `sel` = 2, `result` is 1 exactly when `d2[WIDTH-1:WIDTH-TAG_W]` equals `INT_TAG`. The default `INT_TAG` is 6'h05. No other bit of either operand matters.
- R11: With `sel` = 3, `result` is `d1[0] | d2[0]`.
- R12: `result` is a combinational function of `d1`, `d2` and `sel`. It equals the selected condition's value with no clock and no storage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| d1 | input | WIDTH | First operand word |
| d2 | input | WIDTH | Second operand word |
| sel | input | SEL_W | Binary index of the condition to evaluate |
| result | output | 1 | Value of the selected condition |

## Verification
The bound checks assume that `sel` is a binary index. Values at or above the condition count are legal and must give 0. The checks that tie a condition to its meaning assume the built-in table is in use. The random stimulus draws `sel` across its full range, including the unused codes. Random words alone would almost never hit a match, so the stimulus shapes the operands on purpose. It zeroes `d1`, copies `d1` into `d2`, plants the integer tag, or flips one bit of a near-match. This way every condition is seen both true and false.

// File: rtl/bitpat_pkg.sv
package bitpat_pkg;
   localparam int unsigned DEF_WIDTH    = 32;
   localparam int unsigned DEF_TAG_W    = 6;
   localparam int unsigned DEF_NUM_COND = 5;
   localparam int unsigned DEF_ROWS     = 2;
   localparam logic [5:0]  DEF_INT_TAG  = 6'h05;

   // Meaning of each entry in the built-in condition table
   typedef enum logic [2:0] {
      CND_D1_ZERO  = 3'd0,
      CND_WORD_EQ  = 3'd1,
      CND_INT_TAG  = 3'd2,
      CND_LSB_ANY  = 3'd3,
      CND_EMPTY    = 3'd4
   } builtin_cond_e;
endpackage

// File: rtl/bitpat_row.sv
module bitpat_row #(
   parameter int unsigned W = 32,
   parameter logic         EN = 1'b0,
   parameter logic [W-1:0] D1_CARE = '0,
   parameter logic [W-1:0] D1_VAL  = '0,
   parameter logic [W-1:0] D2_CARE = '0,
   parameter logic [W-1:0] D2_VAL  = '0,
   parameter logic [W-1:0] EQ_CARE = '0
) (
   input  logic [W-1:0] d1,
   input  logic [W-1:0] d2,
   output logic         hit
);
   logic [W-1:0] miss;

   // a position misses when any of its enabled tests fails
   always_comb begin
      miss = (D1_CARE & (d1 ^ D1_VAL))
           | (D2_CARE & (d2 ^ D2_VAL))
           | (EQ_CARE & (d1 ^ d2));
      hit  = EN & ~(|miss);
   end
endmodule

// File: rtl/bitpat_cond.sv
module bitpat_cond #(
   parameter int unsigned W    = 32,
   parameter int unsigned ROWS = 2,
   parameter logic [ROWS-1:0]   EN      = '0,
   parameter logic [ROWS*W-1:0] D1_CARE = '0,
   parameter logic [ROWS*W-1:0] D1_VAL  = '0,
   parameter logic [ROWS*W-1:0] D2_CARE = '0,
   parameter logic [ROWS*W-1:0] D2_VAL  = '0,
   parameter logic [ROWS*W-1:0] EQ_CARE = '0
) (
   input  logic [W-1:0] d1,
   input  logic [W-1:0] d2,
   output logic         hit
);
   logic [ROWS-1:0] row_hit;

   for (genvar r = 0; r < ROWS; r++) begin : g_row
      bitpat_row #(
         .W       (W),
         .EN      (EN[r]),
         .D1_CARE (D1_CARE[r*W +: W]),
         .D1_VAL  (D1_VAL [r*W +: W]),
         .D2_CARE (D2_CARE[r*W +: W]),
         .D2_VAL  (D2_VAL [r*W +: W]),
         .EQ_CARE (EQ_CARE[r*W +: W])
      ) u_row (
         .d1  (d1),
         .d2  (d2),
         .hit (row_hit[r])
      );
   end

   assign hit = |row_hit;
endmodule

// File: rtl/bitpat_sel.sv
module bitpat_sel #(
   parameter int unsigned NUM_COND = 5,
   parameter int unsigned SEL_W    = 3
) (
   input  logic [NUM_COND-1:0] cond_hit,
   input  logic [SEL_W-1:0]    sel,
   output logic                result
);
   localparam int unsigned SPAN = 1 << SEL_W;

   if (SPAN == NUM_COND) begin : g_full
      assign result = cond_hit[sel];
   end else begin : g_padded
      logic [SPAN-1:0] padded;
      assign padded = {{(SPAN-NUM_COND){1'b0}}, cond_hit};
      assign result = padded[sel];
   end
endmodule

// File: rtl/bitpat_cond_eval.sv
module bitpat_cond_eval #(
   parameter int unsigned WIDTH       = bitpat_pkg::DEF_WIDTH,
   parameter int unsigned NUM_COND    = bitpat_pkg::DEF_NUM_COND,
   parameter int unsigned ROWS        = bitpat_pkg::DEF_ROWS,
   parameter int unsigned TAG_W       = bitpat_pkg::DEF_TAG_W,
   parameter logic [TAG_W-1:0] INT_TAG = bitpat_pkg::DEF_INT_TAG,
   parameter bit          USE_BUILTIN = 1'b1,
   parameter int unsigned SEL_W       = (NUM_COND > 1) ? $clog2(NUM_COND) : 1,
   parameter logic [NUM_COND*ROWS-1:0]       USER_EN      = '0,
   parameter logic [NUM_COND*ROWS*WIDTH-1:0] USER_D1_CARE = '0,
   parameter logic [NUM_COND*ROWS*WIDTH-1:0] USER_D1_VAL  = '0,
   parameter logic [NUM_COND*ROWS*WIDTH-1:0] USER_D2_CARE = '0,
   parameter logic [NUM_COND*ROWS*WIDTH-1:0] USER_D2_VAL  = '0,
   parameter logic [NUM_COND*ROWS*WIDTH-1:0] USER_EQ_CARE = '0
) (
   input  logic [WIDTH-1:0] d1,
   input  logic [WIDTH-1:0] d2,
   input  logic [SEL_W-1:0] sel,
   output logic             result
);
   localparam int unsigned NROW   = NUM_COND * ROWS;
   localparam int unsigned TOT    = NROW * WIDTH;
   localparam int unsigned CBITS  = ROWS * WIDTH;
   localparam int unsigned LOW_W  = WIDTH - TAG_W;
   localparam int unsigned DEF_NROW = 10;

   // elaboration checks on the parameter set
   if (TAG_W == 0 || TAG_W >= WIDTH) begin : g_bad_tag
      $fatal(1, "TAG_W must be between 1 and WIDTH-1");
   end
   if (NUM_COND == 0 || ROWS == 0) begin : g_bad_size
      $fatal(1, "NUM_COND and ROWS must be nonzero");
   end
   if ((1 << SEL_W) < NUM_COND) begin : g_bad_sel
      $fatal(1, "SEL_W too narrow for NUM_COND");
   end
   if (USE_BUILTIN && (NUM_COND != 5 || ROWS != 2)) begin : g_bad_builtin
      $fatal(1, "built-in table needs NUM_COND=5 and ROWS=2");
   end

   // building blocks for the built-in table
   localparam logic [WIDTH-1:0] M_ALL  = {WIDTH{1'b1}};
   localparam logic [WIDTH-1:0] M_NONE = {WIDTH{1'b0}};
   localparam logic [WIDTH-1:0] M_LSB  = {{(WIDTH-1){1'b0}}, 1'b1};
   localparam logic [WIDTH-1:0] M_TAG  = {{TAG_W{1'b1}}, {LOW_W{1'b0}}};
   localparam logic [WIDTH-1:0] V_TAG  = {INT_TAG, {LOW_W{1'b0}}};

   // row order, lowest first: c0r0 c0r1 c1r0 c1r1 c2r0 c2r1 c3r0 c3r1 c4r0 c4r1
   localparam logic [DEF_NROW*WIDTH-1:0] B_D1_CARE =
      {M_NONE, M_ALL, M_NONE, M_LSB, M_NONE, M_NONE, M_NONE, M_NONE, M_NONE, M_ALL};
   localparam logic [DEF_NROW*WIDTH-1:0] B_D1_VAL =
      {M_NONE, M_NONE, M_NONE, M_LSB, M_NONE, M_NONE, M_NONE, M_NONE, M_NONE, M_NONE};
   localparam logic [DEF_NROW*WIDTH-1:0] B_D2_CARE =
      {M_NONE, M_NONE, M_LSB, M_NONE, M_NONE, M_TAG, M_NONE, M_NONE, M_NONE, M_NONE};
   localparam logic [DEF_NROW*WIDTH-1:0] B_D2_VAL =
      {M_NONE, M_NONE, M_LSB, M_NONE, M_NONE, V_TAG, M_NONE, M_NONE, M_NONE, M_NONE};
   localparam logic [DEF_NROW*WIDTH-1:0] B_EQ_CARE =
      {M_NONE, M_NONE, M_NONE, M_NONE, M_NONE, M_NONE, M_NONE, M_ALL, M_NONE, M_NONE};
   // c4r0 carries a full mask but stays disabled
   localparam logic [DEF_NROW-1:0] B_EN = 10'b00_1101_0101;

   localparam logic [TOT-1:0]  T_D1_CARE = USE_BUILTIN ? TOT'(B_D1_CARE) : USER_D1_CARE;
   localparam logic [TOT-1:0]  T_D1_VAL  = USE_BUILTIN ? TOT'(B_D1_VAL)  : USER_D1_VAL;
   localparam logic [TOT-1:0]  T_D2_CARE = USE_BUILTIN ? TOT'(B_D2_CARE) : USER_D2_CARE;
   localparam logic [TOT-1:0]  T_D2_VAL  = USE_BUILTIN ? TOT'(B_D2_VAL)  : USER_D2_VAL;
   localparam logic [TOT-1:0]  T_EQ_CARE = USE_BUILTIN ? TOT'(B_EQ_CARE) : USER_EQ_CARE;
   localparam logic [NROW-1:0] T_EN      = USE_BUILTIN ? NROW'(B_EN)     : USER_EN;

   logic [NUM_COND-1:0] cond_hit;

   for (genvar c = 0; c < NUM_COND; c++) begin : g_cond
      bitpat_cond #(
         .W       (WIDTH),
         .ROWS    (ROWS),
         .EN      (T_EN     [c*ROWS  +: ROWS]),
         .D1_CARE (T_D1_CARE[c*CBITS +: CBITS]),
         .D1_VAL  (T_D1_VAL [c*CBITS +: CBITS]),
         .D2_CARE (T_D2_CARE[c*CBITS +: CBITS]),
         .D2_VAL  (T_D2_VAL [c*CBITS +: CBITS]),
         .EQ_CARE (T_EQ_CARE[c*CBITS +: CBITS])
      ) u_cond (
         .d1  (d1),
         .d2  (d2),
         .hit (cond_hit[c])
      );
   end

   bitpat_sel #(
      .NUM_COND (NUM_COND),
      .SEL_W    (SEL_W)
   ) u_sel (
      .cond_hit (cond_hit),
      .sel      (sel),
      .result   (result)
   );
endmodule

// File: rtl/bitpat_cond_eval_chk.sv
module bitpat_cond_eval_chk #(
   parameter int unsigned WIDTH    = 32,
   parameter int unsigned NUM_COND = 5,
   parameter int unsigned SEL_W    = 3,
   parameter int unsigned TAG_W    = 6,
   parameter logic [TAG_W-1:0] INT_TAG = '0,
   parameter bit          BUILTIN  = 1'b1
) (
   input logic [WIDTH-1:0]    d1,
   input logic [WIDTH-1:0]    d2,
   input logic [SEL_W-1:0]    sel,
   input logic                result,
   input logic [NUM_COND-1:0] cond_hit
);
   always_comb begin
      if (int'(sel) >= NUM_COND) begin
         // R7
         sel_range_chk: assert (result == 1'b0)
            else $error("result set for unused select");
      end else begin
         // R12
         sel_route_chk: assert (result == cond_hit[int'(sel)])
            else $error("result differs from selected condition");
      end
   end

   if (BUILTIN) begin : g_builtin
      always_comb begin
         // R8
         d1_zero_chk: assert (cond_hit[0] == (d1 == '0))
            else $error("zero test on d1 wrong");
         // R9
         word_eq_chk: assert (cond_hit[1] == (d1 == d2))
            else $error("equality test wrong");
         // R10
         int_tag_chk: assert (cond_hit[2] == (d2[WIDTH-1 -: TAG_W] == INT_TAG))
            else $error("tag test wrong");
         // R11
         lsb_any_chk: assert (cond_hit[3] == (d1[0] | d2[0]))
            else $error("OR of rows wrong");
         // R6
         empty_cond_chk: assert (cond_hit[4] == 1'b0)
            else $error("condition without enabled rows is set");
      end
   end
endmodule

bind bitpat_cond_eval bitpat_cond_eval_chk #(
   .WIDTH    (WIDTH),
   .NUM_COND (NUM_COND),
   .SEL_W    (SEL_W),
   .TAG_W    (TAG_W),
   .INT_TAG  (INT_TAG),
   .BUILTIN  (USE_BUILTIN)
) u_chk (
   .d1       (d1),
   .d2       (d2),
   .sel      (sel),
   .result   (result),
   .cond_hit (cond_hit)
);

// File: tb/bitpat_cond_eval_test.sv
module bitpat_cond_eval_test;
   localparam int W = 32;
   localparam logic [5:0] TAG = 6'h05;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [W-1:0] d1 = '0;
   logic [W-1:0] d2 = '0;
   logic [2:0]   sel = '0;
   logic         result;
   int           n_vec = 0;
   int           n_bad = 0;
   bit           done = 1'b0;

   always #2 clk = ~clk;

   bitpat_cond_eval uut (
      .d1     (d1),
      .d2     (d2),
      .sel    (sel),
      .result (result)
   );

   function automatic logic model(input logic [W-1:0] a, input logic [W-1:0] b,
                                  input logic [2:0] s);
      case (s)
         3'd0:    return a == '0;
         3'd1:    return a == b;
         3'd2:    return b[W-1 -: 6] == TAG;
         3'd3:    return a[0] | b[0];
         default: return 1'b0;
      endcase
   endfunction

   function automatic string tags(input logic [2:0] s);
      case (s)
         3'd0:    return "R8 R1 R12";
         3'd1:    return "R9 R3 R12";
         3'd2:    return "R10 R2 R4 R12";
         3'd3:    return "R11 R5 R12";
         3'd4:    return "R6 R12";
         default: return "R7";
      endcase
   endfunction

   task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic [2:0] s, input string note);
      logic exp;
      @(negedge clk);
      d1 = a; d2 = b; sel = s;
      #1;
      exp = model(a, b, s);
      n_vec++;
      if (result !== exp) begin
         n_bad++;
         $display("FAIL %s %s: sel=%0d d1=%h d2=%h result=%b expected=%b",
                  tags(s), note, s, a, b, result, exp);
      end
   endtask

   initial begin
      #20000000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not finish, result=%b expected=done", result);
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] a, b;
      logic [2:0]   s;
      void'($urandom(32'h5eed_0421));
      repeat (3) @(posedge clk);
      rst = 1'b0;

      // reset state: zero operands, select 0 -> result 1 (R8)
      apply('0, '0, 3'd0, "reset state");
      // R1 R8: one set bit in d1 defeats the zero test
      apply(32'h8000_0000, '0, 3'd0, "d1 msb set");
      apply(32'h0000_0001, 32'hFFFF_FFFF, 3'd0, "d1 lsb set");
      apply('0, 32'hDEAD_BEEF, 3'd0, "d2 ignored");
      // R3 R9
      apply(32'hA5A5_1234, 32'hA5A5_1234, 3'd1, "equal words");
      apply(32'hA5A5_1234, 32'hA5A5_1235, 3'd1, "lsb differs");
      apply(32'h0000_0000, 32'h8000_0000, 3'd1, "msb differs");
      // R2 R4 R10
      apply(32'h0, {TAG, 26'h3FF_FFFF}, 3'd2, "tag match");
      apply(32'hFFFF_FFFF, {TAG, 26'h0}, 3'd2, "tag match d1 ignored");
      apply({TAG, 26'h0}, {6'h04, 26'h0}, 3'd2, "tag off by lsb");
      apply('0, {6'h25, 26'h0}, 3'd2, "tag off by msb");
      // R5 R11
      apply(32'h0, 32'h0, 3'd3, "neither lsb");
      apply(32'h1, 32'h0, 3'd3, "d1 lsb only");
      apply(32'h0, 32'h1, 3'd3, "d2 lsb only");
      apply(32'h1, 32'h1, 3'd3, "both lsb");
      // R6: empty condition whose disabled row would match
      apply('0, '0, 3'd4, "disabled row");
      // R7
      for (int k = 5; k < 8; k++) apply('0, '0, 3'(k), "unused select");

      // R12: shaped random sweep
      for (int i = 0; i < 4000; i++) begin
         a = $urandom;
         b = $urandom;
         s = 3'($urandom % 8);
         case ($urandom % 6)
            0: a = '0;
            1: b = a;
            2: b = {TAG, b[25:0]};
            3: b = a ^ (32'h1 << ($urandom % 32));
            4: b = {TAG ^ (6'h1 << ($urandom % 6)), b[25:0]};
            default: ;
         endcase
         apply(a, b, s, "random");
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule